// File: doc/BRIEF.md
# Single-Precision Compare Predicate Evaluator

This block takes two 32-bit IEEE-754 single-precision operands and a predicate code and returns one result bit that says whether the chosen relation holds. It also returns two status flags. The invalid flag is raised for NaN inputs according to whether the predicate is a signaling or a quiet one. The denormal flag is raised when either input is subnormal. The unit is purely combinational, so a surrounding pipeline can register its outputs in whatever stage suits it.

The predicate code has five bits. The low four bits pick one of sixteen relations. Bit 4 swaps the signaling and quiet treatment of quiet NaNs without changing the relation. A legacy-mode input limits decoding to the low three bits. Predicate bits 7:5 are never looked at. Ordering follows sign-magnitude rules. Signed zeros compare equal, and subnormals compare by their exact value.

Top module: `fp32_cmp_eval`

## Requirements
- R1: A pair is unordered when either operand is a NaN, meaning an all-ones exponent with a nonzero mantissa. For an unordered pair, the ordered predicates (codes 0,1,2,7,12,13,14 and their +16 forms) return 0, and codes 3,4,5,6,8,9,10 and their +16 forms return 1.
- R2: For ordered pairs, codes 0..15 evaluate these relations. 0 equal, 1 less, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less, 6 not-less-or-equal, 7 ordered, 8 equal, 9 not-greater-or-equal, 10 not-greater, 11 false, 12 not-equal, 13 greater-or-equal, 14 greater, 15 true.
- R3: Code c+16 gives the same result bit as code c for every pair. Its signaling/quiet class is the opposite of code c's class.
- R4: With `legacy_mode`=1 only `pred[2:0]` is decoded, giving codes 0..7. With `legacy_mode`=0, `pred[4:0]` is decoded. `pred[7:5]` is ignored in both modes.
- R5: `flag_invalid` is 1 whenever either operand is a signaling NaN, meaning mantissa bit 22 is clear. This holds for every predicate.
- R6: A quiet NaN operand, with mantissa bit 22 set, raises `flag_invalid` only under a signaling predicate. The signaling codes are 1,2,5,6,9,10,13,14 and 16,19,20,23,24,27,28,31.
- R7: `flag_denormal` is 1 exactly when either operand has a zero exponent and a nonzero mantissa.
- R8: +0 and -0 compare equal and neither is less than the other.
- R9: Non-NaN values are ordered by value. Between two negatives, the larger magnitude is smaller. Infinities sit at the ends of the order, and subnormals compare exactly.
- R10: Codes 11 and 27 always return 0, and codes 15 and 31 always return 1, whatever the operands are, NaNs included.
- R11: `flag_invalid` is 0 when neither operand is a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| pred | input | 8 | Predicate byte, low five bits decoded |
| legacy_mode | input | 1 | 1 selects 3-bit predicate decoding |
| result | output | 1 | 1 when the relation holds |
| flag_invalid | output | 1 | Invalid-operation status |
| flag_denormal | output | 1 | Subnormal-operand status |

## Verification
The bench builds the block with the default exponent width of 8 and mantissa width of 23. At those widths the fixed single-precision encodings used in the requirements are valid, which puts all 32 predicate codes within reach: every signaling/quiet pairing, quiet and signaling NaNs, infinities, signed zeros and subnormals. A vector table covers the relations, and directed sweeps check that each code above 15 matches the code 16 below it. Further sweeps check that legacy decoding, with bits 7:5 varied, matches the plain code 0..7 decode.

// File: rtl/fp32_cmp_eval.sv
module fp32_cmp_eval #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW+MW:0] op_a,
  input  logic [EW+MW:0] op_b,
  input  logic [7:0]     pred,
  input  logic           legacy_mode,
  output logic           result,
  output logic           flag_invalid,
  output logic           flag_denormal
);
  localparam int W = EW + MW + 1;
  localparam logic [15:0] SIG_MASK = 16'h6666;

  logic [W-2:0] mag_a, mag_b;
  logic sa, sb, nan_a, nan_b, snan_a, snan_b, den_a, den_b;
  logic unord, eq, lt, gt, signaling;
  logic [4:0] code;

  assign sa    = op_a[W-1];
  assign sb    = op_b[W-1];
  assign mag_a = op_a[W-2:0];
  assign mag_b = op_b[W-2:0];

  assign nan_a  = (&op_a[W-2:MW]) && (|op_a[MW-1:0]);
  assign nan_b  = (&op_b[W-2:MW]) && (|op_b[MW-1:0]);
  assign snan_a = nan_a && !op_a[MW-1];
  assign snan_b = nan_b && !op_b[MW-1];
  assign den_a  = !(|op_a[W-2:MW]) && (|op_a[MW-1:0]);
  assign den_b  = !(|op_b[W-2:MW]) && (|op_b[MW-1:0]);

  assign code  = legacy_mode ? {2'b00, pred[2:0]} : pred[4:0];
  assign unord = nan_a || nan_b;
  assign eq    = !unord && ((op_a == op_b) || (mag_a == '0 && mag_b == '0));

  always_comb begin
    if (unord || eq)  lt = 1'b0;
    else if (sa != sb) lt = sa;
    else if (!sa)      lt = mag_a < mag_b;
    else               lt = mag_a > mag_b;
  end

  assign gt = !unord && !eq && !lt;

  always_comb begin
    case (code[3:0])
      4'd0:    result = eq;
      4'd1:    result = lt;
      4'd2:    result = lt || eq;
      4'd3:    result = unord;
      4'd4:    result = !eq;
      4'd5:    result = !lt;
      4'd6:    result = !(lt || eq);
      4'd7:    result = !unord;
      4'd8:    result = eq || unord;
      4'd9:    result = lt || unord;
      4'd10:   result = !gt;
      4'd11:   result = 1'b0;
      4'd12:   result = !unord && !eq;
      4'd13:   result = gt || eq;
      4'd14:   result = gt;
      default: result = 1'b1;
    endcase
  end

  assign signaling     = SIG_MASK[code[3:0]] ^ code[4];
  assign flag_invalid  = snan_a || snan_b || (signaling && unord);
  assign flag_denormal = den_a || den_b;
endmodule

module fp32_cmp_eval_chk #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input logic [EW+MW:0] op_a,
  input logic [EW+MW:0] op_b,
  input logic [7:0]     pred,
  input logic           legacy_mode,
  input logic           result,
  input logic           flag_invalid,
  input logic           flag_denormal
);
  logic [4:0] c;
  logic na, nb, qa, qb, da, db;
  assign c  = legacy_mode ? {2'b00, pred[2:0]} : pred[4:0];
  assign na = (&op_a[EW+MW-1:MW]) && (|op_a[MW-1:0]);
  assign nb = (&op_b[EW+MW-1:MW]) && (|op_b[MW-1:0]);
  assign qa = na && op_a[MW-1];
  assign qb = nb && op_b[MW-1];
  assign da = (op_a[EW+MW-1:MW] == '0) && (op_a[MW-1:0] != '0);
  assign db = (op_b[EW+MW-1:MW] == '0) && (op_b[MW-1:0] != '0);

  always_comb begin
    if (!$isunknown({op_a, op_b, pred, legacy_mode})) begin
      if (c[3:0] == 4'd11) AST_FALSE_PRED: assert (!result); // R10
      if (c[3:0] == 4'd15) AST_TRUE_PRED: assert (result); // R10
      if ((na && !qa) || (nb && !qb)) AST_SNAN_INVALID: assert (flag_invalid); // R5
      if (!na && !nb) AST_NO_NAN_NO_INVALID: assert (!flag_invalid); // R11
      if ((na || nb) && (c[3:0] == 4'd0 || c[3:0] == 4'd7)) AST_UNORD_ORDERED_FALSE: assert (!result); // R1
      if ((na || nb) && (c[3:0] == 4'd3 || c[3:0] == 4'd4)) AST_UNORD_NEG_TRUE: assert (result); // R1
      AST_DENORM_FLAG: assert (flag_denormal == (da || db)); // R7
    end
  end
endmodule

bind fp32_cmp_eval fp32_cmp_eval_chk #(.EW(EW), .MW(MW)) u_chk (
  .op_a(op_a), .op_b(op_b), .pred(pred), .legacy_mode(legacy_mode),
  .result(result), .flag_invalid(flag_invalid), .flag_denormal(flag_denormal)
);

// File: tb/sim_fp32_cmp_eval.sv
module sim_fp32_cmp_eval;
  localparam int CLK_PERIOD = 10;

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'h7F80_0001;
  localparam logic [31:0] D1 = 32'h0000_0001, D2 = 32'h0000_0002;
  localparam logic [31:0] PI = 32'h7F80_0000, NI = 32'hFF80_0000;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [7:0]  p;
    logic        lg;
    logic        r;
    logic        i;
    logic        d;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VT [NV] = '{
    '{P1, P2, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 less
    '{P2, P1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0},  // R2
    '{N2, N1, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0},  // R9 negatives
    '{N1, N2, 8'h0E, 1'b0, 1'b1, 1'b0, 1'b0},  // R9 greater
    '{PZ, NZ, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0},  // R8 equal zeros
    '{NZ, PZ, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0},  // R8 not less
    '{D1, D2, 8'h01, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 R9 subnormals
    '{QN, P1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},  // R1 R6 quiet eq
    '{QN, P1, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 signaling lt
    '{QN, P1, 8'h04, 1'b0, 1'b1, 1'b0, 1'b0},  // R1 neq unordered
    '{P1, QN, 8'h08, 1'b0, 1'b1, 1'b0, 1'b0},  // R1 eq unordered
    '{SN, P1, 8'h03, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 snan quiet pred
    '{P1, P1, 8'h0B, 1'b0, 1'b0, 1'b0, 1'b0},  // R10 false
    '{QN, QN, 8'h0F, 1'b0, 1'b1, 1'b0, 1'b0},  // R10 true
    '{QN, P1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 R6 lt quiet
    '{QN, P1, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 eq signaling
    '{P1, P2, 8'h0D, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 ge
    '{P2, P2, 8'h0D, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 ge equal
    '{QN, P1, 8'h0C, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 legacy -> code 4
    '{QN, P1, 8'h1C, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 legacy drops bit 4
    '{QN, P1, 8'h0C, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 full decode code 12
    '{P1, P2, 8'hE1, 1'b0, 1'b1, 1'b0, 1'b0},  // R4 bits 7:5 ignored
    '{PI, P1, 8'h0E, 1'b0, 1'b1, 1'b0, 1'b0},  // R9 +inf
    '{NI, N1, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0},  // R9 -inf
    '{QN, P1, 8'h05, 1'b0, 1'b1, 1'b1, 1'b0},  // R1 R6 nlt
    '{P1, P2, 8'h07, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 ordered
    '{P1, P2, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 R11 unordered no
    '{SN, D1, 8'h1B, 1'b0, 1'b0, 1'b1, 1'b1}   // R5 R7 R10
  };

  logic clk = 1'b0;
  logic [31:0] op_a, op_b;
  logic [7:0]  pred;
  logic        legacy_mode;
  logic        result, flag_invalid, flag_denormal;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fp32_cmp_eval u0 (
    .op_a(op_a), .op_b(op_b), .pred(pred), .legacy_mode(legacy_mode),
    .result(result), .flag_invalid(flag_invalid), .flag_denormal(flag_denormal)
  );

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, logic [7:0] p, logic lg);
    @(negedge clk);
    op_a = a; op_b = b; pred = p; legacy_mode = lg;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic r0, i0;
    logic [31:0] pa [6] = '{P1, N2, PZ, QN, D1, PI};
    logic [31:0] pb [6] = '{P2, N1, NZ, P1, D2, QN};

    // idle state with all-zero inputs: R2 code 0 equal, no flags
    apply(PZ, PZ, 8'h00, 1'b0);
    check("R2 idle result", result, 1'b1);
    check("R11 idle invalid", flag_invalid, 1'b0);
    check("R7 idle denormal", flag_denormal, 1'b0);

    for (int k = 0; k < NV; k++) begin
      apply(VT[k].a, VT[k].b, VT[k].p, VT[k].lg);
      check($sformatf("vector %0d result", k), result, VT[k].r);
      check($sformatf("vector %0d invalid", k), flag_invalid, VT[k].i);
      check($sformatf("vector %0d denormal", k), flag_denormal, VT[k].d);
    end

    // R3: upper half matches lower half in result, quiet NaN invalid flips
    for (int n = 0; n < 6; n++) begin
      for (int c = 0; c < 16; c++) begin
        apply(pa[n], pb[n], 8'(c), 1'b0);
        r0 = result; i0 = flag_invalid;
        apply(pa[n], pb[n], 8'(c + 16), 1'b0);
        check("R3 upper code result", result, r0);
        if (n == 3 || n == 5) check("R3 R6 upper code invalid", flag_invalid, !i0);
      end
    end

    // R4: legacy decode equals full decode of pred[2:0], bits 7:3 varied
    for (int n = 0; n < 6; n++) begin
      for (int c = 0; c < 8; c++) begin
        apply(pa[n], pb[n], 8'(c), 1'b0);
        r0 = result; i0 = flag_invalid;
        for (int hi = 1; hi < 32; hi += 5) begin
          apply(pa[n], pb[n], 8'((hi << 3) | c), 1'b1);
          check("R4 legacy result", result, r0);
          check("R4 legacy invalid", flag_invalid, i0);
        end
      end
    end

    // R10 across all operands
    for (int n = 0; n < 6; n++) begin
      apply(pa[n], pb[n], 8'd27, 1'b0);
      check("R10 false code 27", result, 1'b0);
      apply(pa[n], pb[n], 8'd31, 1'b0);
      check("R10 true code 31", result, 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule